// File: doc/BRIEF.md
# Programmable LCD Timing Generator

This block produces the raster timing for a parallel RGB panel. It drives a horizontal sync, a vertical sync, a data-enable and a pixel clock, plus a one-cycle pixel strobe that a pixel pipeline can use to advance. Each line and each frame is built from four programmable segments, in this order: sync, back porch, active, front porch. Every segment length and every active size is supplied as the desired count minus one.

The pixel rate comes from the source clock. A divide-enable bit selects between a divided rate (divider field plus one source cycles per pixel) and a bypass in which each source cycle is one pixel. Each of the four panel outputs has its own inversion control. A video enable starts the raster, and clearing it lets the current frame finish before every output goes back to its idle level. A frame status flag is set at the start of each vertical sync and is cleared by writing a one to it. An interrupt output is raised while that flag is set and both the master enable and the frame-source enable are on. All configuration arrives on input ports.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset, and while video is off and the raster is idle, horizontal and vertical sync are at their inactive level, data-enable is inactive, the pixel clock is at its low level (all before inversion), the pixel strobe is 0, and the status flag and interrupt are 0.
- R2: With divide-enable at 1 the pixel strobe pulses once every divider+1 source cycles (divider 8'hFF gives 256). With divide-enable at 0 it pulses on every running cycle, whatever the divider field holds.
- R3: Within each pixel period of N source cycles, the uninverted pixel clock is high for the first (N+1)/2 cycles (integer division) and low for the rest.
- R4: A line lasts (hsync+1)+(hback+1)+(hactive+1)+(hfront+1) pixel periods, and horizontal sync is active for the first hsync+1 pixels of each line.
- R5: A frame lasts (vsync+1)+(vback+1)+(vactive+1)+(vfront+1) lines, and vertical sync is active for the first vsync+1 lines of each frame.
- R6: Data-enable is active only when both the pixel and the line are inside their active segments. Its first active cycle in a frame falls (vsync+vback+2) lines plus (hsync+hback+2) pixels after the frame starts, and there are N*(hactive+1)*(vactive+1) active cycles per frame.
- R7: Before inversion, the syncs are active low and data-enable is active high. Each inversion bit (vertical sync, horizontal sync, data-enable, pixel clock) flips its output at all times, idle levels included.
- R8: When video enable is raised while idle, the first cycle after the next clock edge is pixel 0 of line 0, with both syncs active.
- R9: When video enable is cleared, the raster runs to the end of the current frame. The pixel strobe's final pulse falls on the frame's last cycle, and every output is idle in the cycle after that.
- R10: The status flag is set one cycle after vertical sync becomes active, but only when the frame-source enable is 1 and the frame select equals 2'b01. Any other select code, or the source enable at 0, leaves the flag unchanged.
- R11: A status write with data bit 1 clears the flag. A write with data 0 has no effect. A set and a clear in the same cycle leave the flag set.
- R12: The interrupt output is high exactly while the flag is set, the master enable is 1 and the frame-source enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_video_en | input | 1 | Global video enable |
| cfg_div_en | input | 1 | 1 selects the divided pixel rate, 0 selects bypass |
| cfg_div_val | input | DIV_W | Pixel divider minus one |
| cfg_hsync | input | H_W | Horizontal sync width minus one |
| cfg_hback | input | H_W | Horizontal back porch minus one |
| cfg_hact | input | H_W | Active pixels per line minus one |
| cfg_hfront | input | H_W | Horizontal front porch minus one |
| cfg_vsync | input | V_W | Vertical sync lines minus one |
| cfg_vback | input | V_W | Vertical back porch lines minus one |
| cfg_vact | input | V_W | Active lines minus one |
| cfg_vfront | input | V_W | Vertical front porch lines minus one |
| cfg_inv_vs | input | 1 | Invert vertical sync |
| cfg_inv_hs | input | 1 | Invert horizontal sync |
| cfg_inv_de | input | 1 | Invert data-enable |
| cfg_inv_pclk | input | 1 | Invert pixel clock |
| cfg_irq_en | input | 1 | Master interrupt enable |
| cfg_frame_en | input | 1 | Frame interrupt source enable |
| cfg_frame_sel | input | 2 | Frame event select; 2'b01 selects vertical sync |
| sts_wr | input | 1 | Status write strobe |
| sts_wr_data | input | 1 | Status write data; 1 clears the flag |
| lcd_hsync | output | 1 | Horizontal sync to panel |
| lcd_vsync | output | 1 | Vertical sync to panel |
| lcd_de | output | 1 | Data-enable to panel |
| lcd_pclk | output | 1 | Pixel clock to panel |
| pclk_en | output | 1 | One-cycle strobe on the last source cycle of each pixel |
| frame_sts | output | 1 | Frame status flag |
| irq | output | 1 | Frame interrupt |

## Verification
The panel outputs and the pixel strobe are decoded from registered counters, so with the default unregistered outputs they change in the cycle after the edge that advances the counters. A raster started at one falling edge therefore shows pixel 0 of line 0 at the next falling edge, which the bench samples as index 0. The status flag follows the rise of vertical sync by one edge, so it is checked at index 1. A write-one clear takes effect at the next edge, and the interrupt tracks the flag in the same cycle. The final pixel strobe of a stopped frame is expected at index 2*T-1 and the idle outputs at 2*T, where T is the frame length in source cycles. All sampling happens on falling edges, with stimulus driven right after each sample.

// File: rtl/lcd_timing_pkg.sv
package lcd_timing_pkg;
   typedef enum logic [1:0] {
      SEG_SYNC  = 2'd0,
      SEG_BACK  = 2'd1,
      SEG_ACT   = 2'd2,
      SEG_FRONT = 2'd3
   } seg_e;

   localparam int          FSEL_W     = 2;
   localparam logic [1:0]  FSEL_VSYNC = 2'b01;
endpackage

// File: rtl/lcd_axis_cnt.sv
// One raster axis: counts positions and reports which segment is current.
module lcd_axis_cnt
   import lcd_timing_pkg::*;
#(
   parameter int FW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hold,
   input  logic          step,
   input  logic [FW-1:0] len_sync,
   input  logic [FW-1:0] len_back,
   input  logic [FW-1:0] len_act,
   input  logic [FW-1:0] len_front,
   output seg_e          seg,
   output logic          at_end
);
   localparam int CW = FW + 3;

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] end_sync, end_back, end_act, end_tot;

   always_comb begin
      end_sync = {3'b000, len_sync} + CW'(1);
      end_back = end_sync + {3'b000, len_back} + CW'(1);
      end_act  = end_back + {3'b000, len_act} + CW'(1);
      end_tot  = end_act + {3'b000, len_front} + CW'(1);
   end

   always_comb begin
      if (cnt_q < end_sync)      seg = SEG_SYNC;
      else if (cnt_q < end_back) seg = SEG_BACK;
      else if (cnt_q < end_act)  seg = SEG_ACT;
      else                       seg = SEG_FRONT;
   end

   assign at_end = (cnt_q == end_tot - CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (hold)  cnt_q <= '0;
      else if (step)  cnt_q <= at_end ? '0 : cnt_q + CW'(1);
   end
endmodule

// File: rtl/lcd_pclk_div.sv
// Pixel rate divider with bypass; produces a strobe and a panel clock level.
module lcd_pclk_div #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          div_en,
   input  logic [DW-1:0] div_val,
   output logic          tick,
   output logic          pclk_raw
);
   logic [DW-1:0] ph_q;
   logic [DW-1:0] lim;

   assign lim      = div_en ? div_val : '0;
   assign tick     = run && (ph_q >= lim);
   assign pclk_raw = run && (ph_q <= (lim >> 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    ph_q <= '0;
      else if (!run || ph_q >= lim)  ph_q <= '0;
      else                           ph_q <= ph_q + DW'(1);
   end
endmodule

// File: rtl/lcd_frame_irq.sv
// Frame status flag with write-one-to-clear and gated interrupt.
module lcd_frame_irq
   import lcd_timing_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vs_on,
   input  logic              frame_en,
   input  logic [FSEL_W-1:0] frame_sel,
   input  logic              master_en,
   input  logic              wr,
   input  logic              wr_data,
   output logic              sts,
   output logic              irq
);
   logic vs_prev_q;
   logic set_evt;

   assign set_evt = vs_on && !vs_prev_q && frame_en && (frame_sel == FSEL_VSYNC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vs_prev_q <= 1'b0;
         sts       <= 1'b0;
      end else begin
         vs_prev_q <= vs_on;
         if (set_evt)           sts <= 1'b1;
         else if (wr && wr_data) sts <= 1'b0;
      end
   end

   assign irq = sts && master_en && frame_en;
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
   import lcd_timing_pkg::*;
#(
   parameter int H_W     = 11,
   parameter int V_W     = 11,
   parameter int DIV_W   = 8,
   parameter bit OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_video_en,
   input  logic             cfg_div_en,
   input  logic [DIV_W-1:0] cfg_div_val,
   input  logic [H_W-1:0]   cfg_hsync,
   input  logic [H_W-1:0]   cfg_hback,
   input  logic [H_W-1:0]   cfg_hact,
   input  logic [H_W-1:0]   cfg_hfront,
   input  logic [V_W-1:0]   cfg_vsync,
   input  logic [V_W-1:0]   cfg_vback,
   input  logic [V_W-1:0]   cfg_vact,
   input  logic [V_W-1:0]   cfg_vfront,
   input  logic             cfg_inv_vs,
   input  logic             cfg_inv_hs,
   input  logic             cfg_inv_de,
   input  logic             cfg_inv_pclk,
   input  logic             cfg_irq_en,
   input  logic             cfg_frame_en,
   input  logic [1:0]       cfg_frame_sel,
   input  logic             sts_wr,
   input  logic             sts_wr_data,
   output logic             lcd_hsync,
   output logic             lcd_vsync,
   output logic             lcd_de,
   output logic             lcd_pclk,
   output logic             pclk_en,
   output logic             frame_sts,
   output logic             irq
);
   localparam int NOUT = 4;

   if (H_W < 1 || H_W > 16) begin : g_bad_hw
      $error("H_W out of range");
   end
   if (V_W < 1 || V_W > 16) begin : g_bad_vw
      $error("V_W out of range");
   end
   if (DIV_W < 1 || DIV_W > 16) begin : g_bad_dw
      $error("DIV_W out of range");
   end

   logic run_q;
   logic h_end, v_end, frame_end;
   seg_e h_seg, v_seg;
   logic pclk_raw;

   lcd_pclk_div #(.DW(DIV_W)) div_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_q),
      .div_en   (cfg_div_en),
      .div_val  (cfg_div_val),
      .tick     (pclk_en),
      .pclk_raw (pclk_raw)
   );

   lcd_axis_cnt #(.FW(H_W)) hax_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold      (!run_q),
      .step      (pclk_en),
      .len_sync  (cfg_hsync),
      .len_back  (cfg_hback),
      .len_act   (cfg_hact),
      .len_front (cfg_hfront),
      .seg       (h_seg),
      .at_end    (h_end)
   );

   lcd_axis_cnt #(.FW(V_W)) vax_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold      (!run_q),
      .step      (pclk_en && h_end),
      .len_sync  (cfg_vsync),
      .len_back  (cfg_vback),
      .len_act   (cfg_vact),
      .len_front (cfg_vfront),
      .seg       (v_seg),
      .at_end    (v_end)
   );

   assign frame_end = pclk_en && h_end && v_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          run_q <= 1'b0;
      else if (!run_q)                     run_q <= cfg_video_en;
      else if (frame_end && !cfg_video_en) run_q <= 1'b0;
   end

   // Raw levels: syncs low when active, data-enable and clock high when active.
   logic            vs_on;
   logic [NOUT-1:0] raw_nxt, raw_out, inv_vec;

   assign vs_on   = run_q && (v_seg == SEG_SYNC);
   assign raw_nxt = {~(run_q && (h_seg == SEG_SYNC)),
                     ~vs_on,
                     run_q && (h_seg == SEG_ACT) && (v_seg == SEG_ACT),
                     pclk_raw};
   assign inv_vec = {cfg_inv_hs, cfg_inv_vs, cfg_inv_de, cfg_inv_pclk};

   if (OUT_REG) begin : g_out_reg
      logic [NOUT-1:0] raw_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) raw_q <= 4'b1100;
         else        raw_q <= raw_nxt;
      end
      assign raw_out = raw_q;
   end else begin : g_out_comb
      assign raw_out = raw_nxt;
   end

   assign {lcd_hsync, lcd_vsync, lcd_de, lcd_pclk} = raw_out ^ inv_vec;

   lcd_frame_irq irq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .vs_on     (vs_on),
      .frame_en  (cfg_frame_en),
      .frame_sel (cfg_frame_sel),
      .master_en (cfg_irq_en),
      .wr        (sts_wr),
      .wr_data   (sts_wr_data),
      .sts       (frame_sts),
      .irq       (irq)
   );
endmodule

// File: rtl/lcd_timing_chk.sv
module lcd_timing_chk #(
   parameter int DIV_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run_q,
   input logic             pclk_en,
   input logic             cfg_video_en,
   input logic             cfg_div_en,
   input logic [DIV_W-1:0] cfg_div_val,
   input logic             lcd_hsync,
   input logic             lcd_vsync,
   input logic             lcd_de,
   input logic             cfg_inv_hs,
   input logic             cfg_inv_vs,
   input logic             cfg_inv_de,
   input logic             frame_sts,
   input logic             irq,
   input logic             sts_wr,
   input logic             sts_wr_data,
   input logic             cfg_frame_en,
   input logic             cfg_irq_en
);
   logic hs_on, vs_on, de_on;
   assign hs_on = !(lcd_hsync ^ cfg_inv_hs);
   assign vs_on = !(lcd_vsync ^ cfg_inv_vs);
   assign de_on = lcd_de ^ cfg_inv_de;

   AST_DIV_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (pclk_en && cfg_div_en && cfg_div_val != '0) |=>
         (!pclk_en || !$stable(cfg_div_val) || !$stable(cfg_div_en))); // R2

   AST_DE_OUTSIDE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      de_on |-> (!hs_on && !vs_on)); // R6

   AST_FRAME_STARTS_IN_HSYNC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vs_on) |-> hs_on); // R5

   AST_STOP_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run_q) |-> ($past(pclk_en) && !$past(cfg_video_en))); // R9

   AST_STS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_wr && sts_wr_data && !cfg_frame_en) |=> !frame_sts); // R11

   AST_STS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_sts && !(sts_wr && sts_wr_data)) |=> frame_sts); // R11

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (frame_sts && cfg_irq_en)); // R12
endmodule

bind lcd_timing_gen lcd_timing_chk #(.DIV_W(DIV_W)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .run_q        (run_q),
   .pclk_en      (pclk_en),
   .cfg_video_en (cfg_video_en),
   .cfg_div_en   (cfg_div_en),
   .cfg_div_val  (cfg_div_val),
   .lcd_hsync    (lcd_hsync),
   .lcd_vsync    (lcd_vsync),
   .lcd_de       (lcd_de),
   .cfg_inv_hs   (cfg_inv_hs),
   .cfg_inv_vs   (cfg_inv_vs),
   .cfg_inv_de   (cfg_inv_de),
   .frame_sts    (frame_sts),
   .irq          (irq),
   .sts_wr       (sts_wr),
   .sts_wr_data  (sts_wr_data),
   .cfg_frame_en (cfg_frame_en),
   .cfg_irq_en   (cfg_irq_en)
);

// File: tb/lcd_timing_gen_tb_top.sv
`timescale 1ns/1ps
module lcd_timing_gen_tb_top;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       rst_n;
   logic       cfg_video_en, cfg_div_en;
   logic [7:0] cfg_div_val;
   logic [10:0] cfg_hsync, cfg_hback, cfg_hact, cfg_hfront;
   logic [10:0] cfg_vsync, cfg_vback, cfg_vact, cfg_vfront;
   logic       cfg_inv_vs, cfg_inv_hs, cfg_inv_de, cfg_inv_pclk;
   logic       cfg_irq_en, cfg_frame_en;
   logic [1:0] cfg_frame_sel;
   logic       sts_wr, sts_wr_data;
   logic       lcd_hsync, lcd_vsync, lcd_de, lcd_pclk, pclk_en, frame_sts, irq;

   lcd_timing_gen dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_video_en(cfg_video_en),
      .cfg_div_en(cfg_div_en), .cfg_div_val(cfg_div_val),
      .cfg_hsync(cfg_hsync), .cfg_hback(cfg_hback), .cfg_hact(cfg_hact), .cfg_hfront(cfg_hfront),
      .cfg_vsync(cfg_vsync), .cfg_vback(cfg_vback), .cfg_vact(cfg_vact), .cfg_vfront(cfg_vfront),
      .cfg_inv_vs(cfg_inv_vs), .cfg_inv_hs(cfg_inv_hs), .cfg_inv_de(cfg_inv_de),
      .cfg_inv_pclk(cfg_inv_pclk), .cfg_irq_en(cfg_irq_en), .cfg_frame_en(cfg_frame_en),
      .cfg_frame_sel(cfg_frame_sel), .sts_wr(sts_wr), .sts_wr_data(sts_wr_data),
      .lcd_hsync(lcd_hsync), .lcd_vsync(lcd_vsync), .lcd_de(lcd_de), .lcd_pclk(lcd_pclk),
      .pclk_en(pclk_en), .frame_sts(frame_sts), .irq(irq)
   );

   // Vector table: timing fields (minus-one), divider, inversion bits.
   localparam int NV = 4;
   localparam int T_HSW[NV] = '{0, 1, 2, 0};
   localparam int T_HBP[NV] = '{0, 2, 1, 0};
   localparam int T_HAC[NV] = '{3, 4, 1, 0};
   localparam int T_HFP[NV] = '{0, 1, 2, 0};
   localparam int T_VSW[NV] = '{0, 1, 0, 0};
   localparam int T_VBP[NV] = '{0, 0, 1, 0};
   localparam int T_VAC[NV] = '{1, 2, 0, 0};
   localparam int T_VFP[NV] = '{0, 1, 0, 0};
   localparam int T_DEN[NV] = '{0, 1, 0, 1};
   localparam int T_DIV[NV] = '{0, 2, 5, 1};
   localparam int T_IHS[NV] = '{0, 1, 1, 0};
   localparam int T_IVS[NV] = '{0, 1, 0, 1};
   localparam int T_IDE[NV] = '{0, 1, 0, 1};
   localparam int T_IPC[NV] = '{0, 1, 0, 0};

   int n_chk = 0;
   int n_err = 0;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic load_vec(input int v);
      cfg_hsync = 11'(T_HSW[v]); cfg_hback = 11'(T_HBP[v]);
      cfg_hact  = 11'(T_HAC[v]); cfg_hfront = 11'(T_HFP[v]);
      cfg_vsync = 11'(T_VSW[v]); cfg_vback = 11'(T_VBP[v]);
      cfg_vact  = 11'(T_VAC[v]); cfg_vfront = 11'(T_VFP[v]);
      cfg_div_en = T_DEN[v][0]; cfg_div_val = 8'(T_DIV[v]);
      cfg_inv_hs = T_IHS[v][0]; cfg_inv_vs = T_IVS[v][0];
      cfg_inv_de = T_IDE[v][0]; cfg_inv_pclk = T_IPC[v][0];
   endtask

   task automatic clear_sts();
      sts_wr = 1'b1; sts_wr_data = 1'b1;
      @(negedge clk);
      sts_wr = 1'b0; sts_wr_data = 1'b0;
   endtask

   function automatic int hs_on(); return int'(lcd_hsync == cfg_inv_hs); endfunction
   function automatic int vs_on(); return int'(lcd_vsync == cfg_inv_vs); endfunction
   function automatic int de_on(); return int'(lcd_de ^ cfg_inv_de); endfunction

   task automatic check_idle(input string tag);
      chk({tag, " hsync idle"}, int'(lcd_hsync), int'(1'b1 ^ cfg_inv_hs));
      chk({tag, " vsync idle"}, int'(lcd_vsync), int'(1'b1 ^ cfg_inv_vs));
      chk({tag, " de idle"},    int'(lcd_de),    int'(cfg_inv_de));
      chk({tag, " pclk idle"},  int'(lcd_pclk),  int'(cfg_inv_pclk));
      chk({tag, " strobe idle"}, int'(pclk_en), 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : main
      rst_n = 1'b0; cfg_video_en = 1'b0;
      load_vec(0);
      cfg_irq_en = 1'b0; cfg_frame_en = 1'b0; cfg_frame_sel = 2'b00;
      sts_wr = 1'b0; sts_wr_data = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R1 reset");
      chk("R1 status after reset", int'(frame_sts), 0);
      chk("R1 irq after reset", int'(irq), 0);

      // Table walk: two frames per vector, the second one stopped by clearing video enable.
      for (int v = 0; v < NV; v++) begin
         int n, hs, hb, ha, hf, vs, vb, va, vf, ht, vt, exp_len;
         int c_de, c_hs, c_vs, c_hi, c_tk, first_de;
         load_vec(v);
         cfg_irq_en = 1'b1; cfg_frame_en = 1'b1; cfg_frame_sel = 2'b01;
         n  = (T_DEN[v] != 0) ? T_DIV[v] + 1 : 1;
         hs = T_HSW[v] + 1; hb = T_HBP[v] + 1; ha = T_HAC[v] + 1; hf = T_HFP[v] + 1;
         vs = T_VSW[v] + 1; vb = T_VBP[v] + 1; va = T_VAC[v] + 1; vf = T_VFP[v] + 1;
         ht = hs + hb + ha + hf; vt = vs + vb + va + vf;
         exp_len = n * ht * vt;
         @(negedge clk);
         clear_sts();
         check_idle("R7 idle with inversion");
         cfg_video_en = 1'b1;
         c_de = 0; c_hs = 0; c_vs = 0; c_hi = 0; c_tk = 0; first_de = -1;
         for (int i = 0; i <= 2 * exp_len; i++) begin
            @(negedge clk);
            if (i < exp_len) begin
               c_de += de_on(); c_hs += hs_on(); c_vs += vs_on();
               c_hi += int'(lcd_pclk ^ cfg_inv_pclk); c_tk += int'(pclk_en);
               if (first_de < 0 && de_on() == 1) first_de = i;
            end
            if (i == 0) begin
               chk("R8 first cycle vsync", vs_on(), 1);
               chk("R8 first cycle hsync", hs_on(), 1);
               chk("R12 irq before set", int'(irq), 0);
            end
            if (i == 1) begin
               chk("R10 status set after vsync", int'(frame_sts), 1);
               chk("R12 irq with enables", int'(irq), 1);
            end
            if (i == exp_len) begin
               chk("R5 next frame starts", vs_on(), 1);
               cfg_video_en = 1'b0;
            end
            if (i == 2 * exp_len - 1) chk("R9 last strobe", int'(pclk_en), 1);
            if (i == 2 * exp_len) check_idle("R9 stopped");
         end
         chk("R2 strobes per frame", c_tk, ht * vt);
         chk("R3 pclk high cycles", c_hi, ht * vt * ((n + 1) / 2));
         chk("R4 hsync cycles", c_hs, n * hs * vt);
         chk("R5 vsync cycles", c_vs, n * ht * vs);
         chk("R6 de cycles", c_de, n * ha * va);
         chk("R6 first de", first_de, n * (ht * (vs + vb) + hs + hb));
      end

      // Largest divider: 256 source cycles per pixel.
      begin
         int t1, t2;
         load_vec(0);
         cfg_div_en = 1'b1; cfg_div_val = 8'hFF;
         cfg_video_en = 1'b1;
         t1 = -1; t2 = -1;
         for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (pclk_en) begin
               if (t1 < 0) t1 = i;
               else if (t2 < 0) t2 = i;
            end
         end
         chk("R2 max divider gap", t2 - t1, 256);
         cfg_video_en = 1'b0;
         rst_n = 1'b0;
         @(negedge clk);
         rst_n = 1'b1;
         @(negedge clk);
         check_idle("R1 reset mid frame");
      end

      // Interrupt gating and write-one-to-clear (frame of 35 cycles).
      load_vec(0);
      cfg_irq_en = 1'b0; cfg_frame_en = 1'b1; cfg_frame_sel = 2'b01;
      clear_sts();
      cfg_video_en = 1'b1;
      for (int i = 0; i <= 36; i++) begin
         @(negedge clk);
         if (i == 2) begin
            chk("R10 status set", int'(frame_sts), 1);
            chk("R12 irq masked", int'(irq), 0);
            sts_wr = 1'b1; sts_wr_data = 1'b0;
         end
         if (i == 3) begin
            chk("R11 write zero no effect", int'(frame_sts), 1);
            sts_wr_data = 1'b1;
         end
         if (i == 4) begin
            chk("R11 write one clears", int'(frame_sts), 0);
            sts_wr = 1'b0; sts_wr_data = 1'b0;
            cfg_irq_en = 1'b1;
         end
         if (i == 5) chk("R12 irq off with flag clear", int'(irq), 0);
         if (i == 36) begin
            chk("R10 set on next frame", int'(frame_sts), 1);
            chk("R12 irq on", int'(irq), 1);
         end
      end

      // Other frame select code, then source disabled: no status set.
      clear_sts();
      cfg_frame_sel = 2'b10;
      repeat (80) @(negedge clk);
      chk("R10 other select ignored", int'(frame_sts), 0);
      cfg_frame_sel = 2'b01; cfg_frame_en = 1'b0;
      repeat (80) @(negedge clk);
      chk("R10 source disabled ignored", int'(frame_sts), 0);
      chk("R12 irq needs source enable", int'(irq), 0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule